// File: doc/BRIEF.md
# GPIO Sleep Wake-Up Edge Detector

This block watches sixteen general-purpose input pins while the system is asleep. It decides whether a transition on any of them should bring the system back up. Each pin is first brought into the local clock domain by a synchronizer chain. Its synchronized level is then compared with the value it had one clock earlier, which yields rising and falling edge pulses. A pin's edge counts as a wake event only when three conditions hold: the sleep input is high, the pin's general wake enable is set, and the matching edge-type enable is set. Qualifying events set bits in a sticky cause vector. The block's wake request stays high while any cause bit is set.

Software sets the block up through a simple 32-bit register bus with a write strobe, a word address and combinational read data. There are three enable registers (per-pin wake, per-pin rising, per-pin falling) and one status register that is cleared by writing ones. Two active-low fault inputs report a supply fault and a battery fault. When either fault asserts, the rising-edge enables are forced back to a safe pattern that leaves only pins 0 and 1 able to wake the system. An immunity control bit in the wake enable register switches this override off. The watchdog and GPIO reset pulses put all registers back to their reset values.

Top module: `gpio_wake_detect`

## Requirements
- R1: After `rstN` low, or after a one-cycle high pulse on `wdtRst` or `gpioRst`, the registers read enable = 0x0000_0000, rise = 0x0000_0003, fall = 0x0000_0000 and status = 0x0000_0000.
- R2: Address bits [3:2] select the register: 0x0 is wake enable (bits 15:0 per pin, bit 31 fault immunity), 0x4 is rise enable (bits 15:0), 0x8 is fall enable (bits 15:0) and 0xC is status (bits 15:0 cause, bit 31 request). All other bits read as zero, and writes to them are ignored.
- R3: Each pin passes through two synchronizer flops and then one history flop. A pin change that is set up before clock edge k shows in the cause vector right after edge k+2, and not before.
- R4: A cause bit sets only if all three hold: the sleep input is high, the pin's wake enable bit is set, and the edge type seen is enabled for that pin.
- R5: A falling edge sets a cause bit only through the fall enable register. A rising edge sets a cause bit only through the rise enable register.
- R6: Cause bits stay set until software writes 1 to them at offset 0xC. Bits written as 0 keep their value.
- R7: `wakeReq` is high exactly when any cause bit is set, and `wakeCause` equals status bits 15:0.
- R8: When immunity is 0, a high-to-low transition on `vddFaultN` or `battFaultN` reloads the rise register with 0x0000_0003. A fault level that is set up before edge k takes effect at edge k+2.
- R9: When immunity is 1, faults leave the wake, rise and fall enable registers unchanged.
- R10: If a fault reload and a bus write to the rise register land in the same cycle, the reload wins and the register reads 0x0000_0003.
- R11: If a pin's cause bit is being set and cleared by a status write in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low hardware reset |
| wdtRst | input | 1 | Watchdog reset pulse, synchronous, active high |
| gpioRst | input | 1 | GPIO reset pulse, synchronous, active high |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register byte address |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| gpioIn | input | 16 | Asynchronous GPIO pin levels |
| sleepIn | input | 1 | High while the system sleeps |
| vddFaultN | input | 1 | Active-low supply fault |
| battFaultN | input | 1 | Active-low battery fault |
| wakeReq | output | 1 | Sticky wake request |
| wakeCause | output | 16 | Pins that caused the wake |

## Verification
The bench forces two pairs of actions into one cycle. In the first pair, a supply fault is started, and the bus write of 0xFFFF to the rise register is timed so it lands on the exact edge where the synchronized fault reloads that register. The register must then read 0x3. In the second pair, a pin-5 falling edge is captured on the same edge where a status write clears bits 0 and 5. The cause must then be 0x20: bit 0 has been cleared and bit 5 is kept. Both are judged after the edge through the bus read port and the wake outputs.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_RISE   = 2'd1,
    SEL_FALL   = 2'd2,
    SEL_STATUS = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrEnable;
    logic wrRise;
    logic wrFall;
    logic clrStatus;
    logic faultReload;
    logic softInit;
  } wakeStrobes_t;

endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wdtRst,
  input  logic              gpioRst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              vddFaultN,
  input  logic              battFaultN,
  input  logic              faultImmune,
  output wakeStrobes_t      strobes,
  output regSel_e           rdSel
);

  localparam int SEL_LSB = 2;

  logic [SYNC_STAGES-1:0] vddSync;
  logic [SYNC_STAGES-1:0] battSync;
  logic                   faultLevel;
  logic                   faultPrev;
  logic                   faultStart;
  logic                   addrAligned;

  // Fault inputs are asynchronous; both chains idle at the inactive (high) level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vddSync   <= '1;
      battSync  <= '1;
      faultPrev <= 1'b0;
    end else begin
      vddSync   <= {vddSync[SYNC_STAGES-2:0], vddFaultN};
      battSync  <= {battSync[SYNC_STAGES-2:0], battFaultN};
      faultPrev <= faultLevel;
    end
  end

  assign faultLevel = ~(vddSync[SYNC_STAGES-1] & battSync[SYNC_STAGES-1]);
  assign faultStart = faultLevel & ~faultPrev;

  // Word-aligned decode; upper address bits must be zero for a hit.
  assign addrAligned = (busAddr[SEL_LSB-1:0] == '0) && ((busAddr >> (SEL_LSB + 2)) == '0);
  assign rdSel       = regSel_e'(busAddr[SEL_LSB+1:SEL_LSB]);

  always_comb begin
    strobes             = '0;
    strobes.softInit    = wdtRst | gpioRst;
    strobes.faultReload = faultStart & ~faultImmune;
    if (busWrEn && addrAligned) begin
      unique case (rdSel)
        SEL_ENABLE: strobes.wrEnable  = 1'b1;
        SEL_RISE:   strobes.wrRise    = 1'b1;
        SEL_FALL:   strobes.wrFall    = 1'b1;
        SEL_STATUS: strobes.clrStatus = 1'b1;
        default:    strobes           = strobes;
      endcase
    end
  end

  // R8: a fault start produces a single reload pulse, never a level
  p_reload_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.faultReload |=> !strobes.faultReload);

  // R2: at most one register write strobe per cycle
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrEnable, strobes.wrRise, strobes.wrFall, strobes.clrStatus}));

endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int                NUM_PINS    = 16,
  parameter int                DATA_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter int                IMMUNE_BIT  = 31,
  parameter logic [NUM_PINS-1:0] RISE_RST  = 16'h0003
) (
  input  logic                clk,
  input  logic                rstN,
  input  wakeStrobes_t        strobes,
  input  regSel_e             rdSel,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [NUM_PINS-1:0] gpioIn,
  input  logic                sleepIn,
  output logic [DATA_W-1:0]   busRdData,
  output logic                wakeReq,
  output logic [NUM_PINS-1:0] wakeCause,
  output logic                faultImmune
);

  localparam logic [DATA_W-1:0] PIN_MASK  = DATA_W'((64'd1 << NUM_PINS) - 64'd1);
  localparam logic [DATA_W-1:0] EN_MASK   = PIN_MASK | (DATA_W'(1) << IMMUNE_BIT);
  localparam logic [DATA_W-1:0] RISE_INIT = DATA_W'(RISE_RST);
  localparam int                REQ_BIT   = DATA_W - 1;

  logic [NUM_PINS-1:0] syncStage [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinLevel;
  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] riseSeen;
  logic [NUM_PINS-1:0] fallSeen;
  logic [NUM_PINS-1:0] pinHit;
  logic [DATA_W-1:0]   enableReg;
  logic [DATA_W-1:0]   riseReg;
  logic [DATA_W-1:0]   fallReg;
  logic [NUM_PINS-1:0] causeReg;
  logic [NUM_PINS-1:0] clearMask;

  // Synchronizer chain plus one history stage for edge comparison.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
      pinPrev <= '0;
    end else begin
      syncStage[0] <= gpioIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
      pinPrev <= pinLevel;
    end
  end

  assign pinLevel = syncStage[SYNC_STAGES-1];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
      assign riseSeen[gi] = pinLevel[gi] & ~pinPrev[gi];
      assign fallSeen[gi] = ~pinLevel[gi] & pinPrev[gi];
      assign pinHit[gi]   = sleepIn & enableReg[gi] &
                            ((riseSeen[gi] & riseReg[gi]) | (fallSeen[gi] & fallReg[gi]));
    end
  endgenerate

  assign clearMask = strobes.clrStatus ? busWrData[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      riseReg   <= RISE_INIT;
      fallReg   <= '0;
      causeReg  <= '0;
    end else if (strobes.softInit) begin
      enableReg <= '0;
      riseReg   <= RISE_INIT;
      fallReg   <= '0;
      causeReg  <= '0;
    end else begin
      if (strobes.wrEnable) enableReg <= busWrData & EN_MASK;
      if (strobes.faultReload) riseReg <= RISE_INIT;
      else if (strobes.wrRise) riseReg <= busWrData & PIN_MASK;
      if (strobes.wrFall) fallReg <= busWrData & PIN_MASK;
      // New hits take precedence over a clear in the same cycle.
      causeReg <= (causeReg & ~clearMask) | pinHit;
    end
  end

  assign faultImmune = enableReg[IMMUNE_BIT];
  assign wakeCause   = causeReg;
  assign wakeReq     = |causeReg;

  always_comb begin
    busRdData = '0;
    unique case (rdSel)
      SEL_ENABLE: busRdData = enableReg;
      SEL_RISE:   busRdData = riseReg;
      SEL_FALL:   busRdData = fallReg;
      SEL_STATUS: begin
        busRdData[NUM_PINS-1:0] = causeReg;
        busRdData[REQ_BIT]      = wakeReq;
      end
      default:    busRdData = '0;
    endcase
  end

  // R1: a soft reset pulse restores every register
  p_soft_init_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.softInit |=> (riseReg == RISE_INIT && enableReg == '0 && fallReg == '0 && causeReg == '0));

  // R2: reserved read-back bits stay zero
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[REQ_BIT-1:NUM_PINS] == '0);

  // R4: no new cause bit appears while awake
  p_awake_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepIn && !strobes.softInit) |=> ((causeReg & ~$past(causeReg)) == '0));

  // R6: cause bits only drop through a clear write or soft reset
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clrStatus && !strobes.softInit) |=> (($past(causeReg) & ~causeReg) == '0));

  // R8 / R10: a reload leaves the safe pattern even against a write
  p_fault_reload_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.faultReload && !strobes.softInit) |=> (riseReg == RISE_INIT));

  // R9: with immunity set and no bus access, the rise enables hold
  p_immune_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (faultImmune && !strobes.wrRise && !strobes.softInit) |=> $stable(riseReg));

  // R11: hits survive a same-cycle clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrStatus && !strobes.softInit && pinHit != '0) |=> ((causeReg & $past(pinHit)) == $past(pinHit)));

endmodule

// File: rtl/gpio_wake_detect.sv
module gpio_wake_detect
  import wake_pkg::*;
#(
  parameter int                  NUM_PINS    = 16,
  parameter int                  DATA_W      = 32,
  parameter int                  ADDR_W      = 4,
  parameter int                  SYNC_STAGES = 2,
  parameter int                  IMMUNE_BIT  = 31,
  parameter logic [NUM_PINS-1:0] RISE_RST    = 16'h0003
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wdtRst,
  input  logic                gpioRst,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] gpioIn,
  input  logic                sleepIn,
  input  logic                vddFaultN,
  input  logic                battFaultN,
  output logic                wakeReq,
  output logic [NUM_PINS-1:0] wakeCause
);

  wakeStrobes_t strobes;
  regSel_e      rdSel;
  logic         faultImmune;

  wake_ctrl #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wdtRst      (wdtRst),
    .gpioRst     (gpioRst),
    .busWrEn     (busWrEn),
    .busAddr     (busAddr),
    .vddFaultN   (vddFaultN),
    .battFaultN  (battFaultN),
    .faultImmune (faultImmune),
    .strobes     (strobes),
    .rdSel       (rdSel)
  );

  wake_datapath #(
    .NUM_PINS    (NUM_PINS),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES),
    .IMMUNE_BIT  (IMMUNE_BIT),
    .RISE_RST    (RISE_RST)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rdSel       (rdSel),
    .busWrData   (busWrData),
    .gpioIn      (gpioIn),
    .sleepIn     (sleepIn),
    .busRdData   (busRdData),
    .wakeReq     (wakeReq),
    .wakeCause   (wakeCause),
    .faultImmune (faultImmune)
  );

endmodule

// File: tb/gpio_wake_detect_bench.sv
`timescale 1ns/1ps
module gpio_wake_detect_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wdtRst = 1'b0;
  logic        gpioRst = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [15:0] gpioIn = '0;
  logic        sleepIn = 1'b0;
  logic        vddFaultN = 1'b1;
  logic        battFaultN = 1'b1;
  logic        wakeReq;
  logic [15:0] wakeCause;

  localparam logic [3:0] A_EN = 4'h0, A_RISE = 4'h4, A_FALL = 4'h8, A_STAT = 4'hC;

  gpio_wake_detect u_gpio_wake_detect (
    .clk(clk), .rstN(rstN), .wdtRst(wdtRst), .gpioRst(gpioRst),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .gpioIn(gpioIn), .sleepIn(sleepIn), .vddFaultN(vddFaultN), .battFaultN(battFaultN),
    .wakeReq(wakeReq), .wakeCause(wakeCause)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          isPort;
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  expItem_t    curItem;
  logic [31:0] actual;
  int          vectors = 0;
  int          miscompares = 0;
  bit          finished = 1'b0;

  // Monitor: pops one expectation per falling edge and compares.
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      curItem = expQ.pop_front();
      actual  = curItem.isPort ? {wakeReq, 15'b0, wakeCause} : busRdData;
      vectors++;
      if (actual !== curItem.exp) begin
        miscompares++;
        $display("FAIL %s: got %h expected %h", curItem.tag, actual, curItem.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    step();
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic expectReg(logic [3:0] a, logic [31:0] e, string t);
    busAddr = a;
    expQ.push_back('{isPort: 1'b0, exp: e, tag: t});
    @(negedge clk);
    #1;
  endtask

  task automatic expectWake(logic [15:0] cause, string t);
    expQ.push_back('{isPort: 1'b1, exp: {(cause != 0), 15'b0, cause}, tag: t});
    @(negedge clk);
    #1;
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(2);

    // R1: reset values
    expectReg(A_EN,   32'h0000_0000, "R1 enable reset");
    expectReg(A_RISE, 32'h0000_0003, "R1 rise reset");
    expectReg(A_FALL, 32'h0000_0000, "R1 fall reset");
    expectReg(A_STAT, 32'h0000_0000, "R1 status reset");
    expectWake(16'h0, "R7 idle outputs");

    // R2: reserved bits ignored on write, read as zero
    wr(A_EN, 32'hFFFF_FFFF);
    expectReg(A_EN, 32'h8000_FFFF, "R2 enable mask");
    wr(A_RISE, 32'hFFFF_FFFF);
    expectReg(A_RISE, 32'h0000_FFFF, "R2 rise mask");
    wr(A_FALL, 32'hABCD_1234);
    expectReg(A_FALL, 32'h0000_1234, "R2 fall mask");

    wr(A_EN, 32'h0000_0023);
    wr(A_RISE, 32'h0000_0007);
    wr(A_FALL, 32'h0000_0020);

    // R4: sleep low blocks wake
    gpioIn[0] = 1'b1; waitN(5);
    expectWake(16'h0, "R4 awake ignores edge");
    gpioIn[0] = 1'b0; waitN(5);
    sleepIn = 1'b1; step();

    // R4: wake enable clear blocks wake (pin 2 rise enabled only)
    gpioIn[2] = 1'b1; waitN(5);
    expectWake(16'h0, "R4 wake enable gate");
    gpioIn[2] = 1'b0; waitN(5);

    // R3: latency through synchronizer and history stage
    gpioIn[1] = 1'b1;
    step(); step();
    expectWake(16'h0, "R3 not yet after two edges");
    step();
    expectWake(16'h0002, "R3 captured on third edge");
    expectReg(A_STAT, 32'h8000_0002, "R7 status readback");

    // R6: sticky, write-one-to-clear
    gpioIn[1] = 1'b0; waitN(5);
    expectWake(16'h0002, "R5 fall not enabled on pin1");
    wr(A_STAT, 32'h0000_0001);
    expectWake(16'h0002, "R6 clear other bit keeps");
    wr(A_STAT, 32'h0000_0002);
    expectWake(16'h0000, "R6 clear by one");

    // R5: falling edge via fall register
    gpioIn[5] = 1'b1; waitN(5);
    expectWake(16'h0, "R5 rise not enabled on pin5");
    gpioIn[5] = 1'b0; waitN(5);
    expectWake(16'h0020, "R5 fall wake pin5");
    wr(A_STAT, 32'h0000_FFFF);

    // R11: capture and clear collide
    gpioIn[0] = 1'b1; waitN(5);
    expectWake(16'h0001, "R4 pin0 rise wake");
    gpioIn[5] = 1'b1; waitN(5);
    gpioIn[5] = 1'b0;
    step(); step();
    busAddr = A_STAT; busWrData = 32'h0000_0021; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0; busWrData = '0;
    expectWake(16'h0020, "R11 set wins over clear");
    wr(A_STAT, 32'h0000_FFFF);

    // R10: fault reload collides with rise write
    vddFaultN = 1'b0;
    step(); step();
    busAddr = A_RISE; busWrData = 32'h0000_FFFF; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0; busWrData = '0;
    expectReg(A_RISE, 32'h0000_0003, "R10 reload beats write");
    vddFaultN = 1'b1; waitN(5);

    // R8: battery fault reload
    wr(A_RISE, 32'h0000_00F0);
    battFaultN = 1'b0; waitN(5);
    expectReg(A_RISE, 32'h0000_0003, "R8 battery fault reload");
    battFaultN = 1'b1; waitN(5);

    // R9: immunity
    wr(A_EN, 32'h8000_0023);
    wr(A_RISE, 32'h0000_00F0);
    vddFaultN = 1'b0; waitN(5);
    expectReg(A_RISE, 32'h0000_00F0, "R9 rise unchanged");
    expectReg(A_EN,   32'h8000_0023, "R9 enable unchanged");
    expectReg(A_FALL, 32'h0000_0020, "R9 fall unchanged");
    vddFaultN = 1'b1; waitN(5);

    // R1: watchdog and GPIO reset pulses
    step(); wdtRst = 1'b1; step(); wdtRst = 1'b0;
    expectReg(A_RISE, 32'h0000_0003, "R1 watchdog rise");
    expectReg(A_EN,   32'h0000_0000, "R1 watchdog enable");
    wr(A_RISE, 32'h0000_0055);
    wr(A_FALL, 32'h0000_0011);
    step(); gpioRst = 1'b1; step(); gpioRst = 1'b0;
    expectReg(A_RISE, 32'h0000_0003, "R1 gpio reset rise");
    expectReg(A_FALL, 32'h0000_0000, "R1 gpio reset fall");

    waitN(2);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule